// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a free-running tick timer for a processor subsystem. A down-counter of `CNT_W` bits (24 by default) decrements once per clock while the timer is enabled. When it reaches zero it takes the reload value on the next enabled clock, and that cycle does not decrement. So a reload value of N gives one zero crossing every N+1 clocks. Each transition into zero sets a sticky status flag. If the tick interrupt is enabled, the same transition also raises a single-cycle interrupt request.

Software reaches the block through a single-cycle register port with three registers: control/status, reload and current value. Read data is combinational from the address. A write takes effect at the clock edge on which it is strobed. Writing the current-value register always clears the counter and the status flag, whatever data is written. Reading the control/status register with the read strobe clears the flag. No data streams through the block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `tick_timer`

## Requirements
- R1: After reset, all three registers read zero and `irq` is low.
- R2: While the enable bit (control bit 0) is set and the counter is non-zero, the counter drops by one on every clock. While the enable bit is clear, the counter holds its value.
- R3: When the counter is zero and the timer is enabled, the next clock loads the reload value without decrementing, so the crossing period is reload+1 clocks.
- R4: The clock on which the counter moves from 1 to 0 sets the sticky flag, read at control bit 16.
- R5: A read of the control/status register (offset 0x0) with `reg_rd` high clears the flag on that clock, unless a new zero transition happens on the same clock, in which case the flag stays set.
- R6: A write of any data to the current-value register (offset 0x8) makes it read zero on the next cycle and clears the flag.
- R7: `irq` is high for exactly one cycle, coinciding with each 1-to-0 transition, and only when the interrupt-enable bit (control bit 1) is set.
- R8: With a reload value of 0 the counter stays at zero after reaching it, and the flag is not set again.
- R9: The offsets are control/status 0x0, reload 0x4 and current value 0x8. Only the low `CNT_W` bits of reload and current value exist, and the remaining bits read zero. Any other offset reads zero.
- R10: A write to the control register stores bits 0 and 1 and leaves the flag unchanged. A write to reload stores the low `CNT_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; side effects only (clears the flag on a control read) |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | One-cycle tick interrupt request |

## Verification
The bench builds the timer with `CNT_W` = 8 and keeps the 32-bit data path. With that width, a reload of 255 is the largest value, and its 256-clock period fits in a short run. A write of all ones shows the unimplemented upper bits reading zero. A walked table of reload values checks the reload+1 period, down to the reload of 1 that gives a two-cycle period. Directed cases then cover the flag clear on read, the current-value clear, interrupt masking and the stop at a reload of zero.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned OFS_CTRL   = 'h0;
  localparam int unsigned OFS_RELOAD = 'h4;
  localparam int unsigned OFS_CUR    = 'h8;

  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_IRQ_EN = 1;
  localparam int unsigned BIT_FLAG   = 16;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_CUR    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode(input int unsigned ofs);
    case (ofs)
      OFS_CTRL:   decode = SEL_CTRL;
      OFS_RELOAD: decode = SEL_RELOAD;
      OFS_CUR:    decode = SEL_CUR;
      default:    decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  cur_val,
  input  logic              flag,
  output logic              ctrl_en,
  output logic              ctrl_irq_en,
  output logic [CNT_W-1:0]  reload_val,
  output logic              cur_wr,
  output logic              ctrl_rd,
  output logic [DATA_W-1:0] reg_rdata
);
  reg_sel_e sel;

  always_comb sel = decode(int'(unsigned'(reg_addr)));

  assign cur_wr  = reg_wr && (sel == SEL_CUR);
  assign ctrl_rd = reg_rd && (sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en     <= 1'b0;
      ctrl_irq_en <= 1'b0;
      reload_val  <= '0;
    end else if (reg_wr) begin
      if (sel == SEL_CTRL) begin
        ctrl_en     <= reg_wdata[BIT_EN];
        ctrl_irq_en <= reg_wdata[BIT_IRQ_EN];
      end
      if (sel == SEL_RELOAD) reload_val <= reg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CTRL: begin
        reg_rdata[BIT_EN]     = ctrl_en;
        reg_rdata[BIT_IRQ_EN] = ctrl_irq_en;
        reg_rdata[BIT_FLAG]   = flag;
      end
      SEL_RELOAD: reg_rdata[CNT_W-1:0] = reload_val;
      SEL_CUR:    reg_rdata[CNT_W-1:0] = cur_val;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cur_wr,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cur_val,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_zero;

  assign at_zero  = (cur_val == '0);
  // Taken when the next edge moves the count from one to zero.
  assign zero_evt = en && !cur_wr && (cur_val == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_val <= '0;
    else if (cur_wr)  cur_val <= '0;
    else if (en) begin
      if (at_zero) cur_val <= reload_val;
      else         cur_val <= cur_val - ONE;
    end
  end
endmodule

// File: rtl/tick_flag.sv
module tick_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_evt,
  input  logic ctrl_rd,
  input  logic cur_wr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (zero_evt)               flag <= 1'b1;
      else if (ctrl_rd || cur_wr) flag <= 1'b0;
      irq <= zero_evt && irq_en;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic             ctrl_en;
  logic             ctrl_irq_en;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cur_val;
  logic             cur_wr;
  logic             ctrl_rd;
  logic             zero_evt;
  logic             flag;

  tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cur_val(cur_val),
    .flag(flag), .ctrl_en(ctrl_en), .ctrl_irq_en(ctrl_irq_en),
    .reload_val(reload_val), .cur_wr(cur_wr), .ctrl_rd(ctrl_rd),
    .reg_rdata(reg_rdata)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .cur_wr(cur_wr),
    .reload_val(reload_val), .cur_val(cur_val), .zero_evt(zero_evt)
  );

  tick_flag u_flag (
    .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .ctrl_rd(ctrl_rd),
    .cur_wr(cur_wr), .irq_en(ctrl_irq_en), .flag(flag), .irq(irq)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             irq_en,
  input logic             cur_wr,
  input logic             ctrl_rd,
  input logic [CNT_W-1:0] reload_val,
  input logic [CNT_W-1:0] cur_val,
  input logic             flag,
  input logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cur_wr && cur_val != '0) |=> (cur_val == $past(cur_val) - ONE));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cur_wr) |=> $stable(cur_val));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cur_wr && cur_val == '0) |=> (cur_val == $past(reload_val)));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cur_wr && cur_val == ONE) |=> flag);

  p_flag_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !(en && cur_val == ONE)) |=> !flag);

  p_cur_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (cur_val == '0 && !flag));

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && cur_val == '0));

  p_stay_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cur_wr && cur_val == '0 && reload_val == '0) |=> (cur_val == '0 && !irq));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .irq_en(ctrl_irq_en),
  .cur_wr(cur_wr), .ctrl_rd(ctrl_rd), .reload_val(reload_val),
  .cur_val(cur_val), .flag(flag), .irq(irq)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_REL  = 4'h4;
  localparam logic [ADDR_W-1:0] A_CUR  = 4'h8;
  localparam int FLAGB = 16;

  // {reload value, expected crossing period in clocks}
  localparam int NVEC = 5;
  localparam logic [16:0] VEC [NVEC] = '{
    {8'd1, 9'd2}, {8'd2, 9'd3}, {8'd5, 9'd6}, {8'd17, 9'd18}, {8'd255, 9'd256}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tick_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] peek(input logic [ADDR_W-1:0] a);
    reg_addr = a;
    return reg_rdata;
  endfunction

  task automatic peek_t(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic rd_strobe(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    reg_addr = a; reg_rd = 1'b1; #1; v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt;
    bit irq_seen;
    repeat (3) @(negedge clk);
    // R1: reset state
    peek_t(A_CTRL, v); check("R1 ctrl", v, 0);
    peek_t(A_REL, v);  check("R1 reload", v, 0);
    peek_t(A_CUR, v);  check("R1 cur", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: register map and width
    wr(A_REL, 32'hFFFF_FFFF);
    peek_t(A_REL, v); check("R9 reload upper bits zero", v, 32'h0000_00FF);
    peek_t(4'hC, v);  check("R9 unmapped offset", v, 0);
    // R10: ctrl bits stored
    wr(A_CTRL, 32'hFFFF_FFFC);
    peek_t(A_CTRL, v); check("R10 ctrl bits clear", v, 0);

    // Table walk: R3 / R7 periods
    for (int i = 0; i < NVEC; i++) begin
      wr(A_CTRL, 32'h0);
      wr(A_REL, {24'd0, VEC[i][16:9]});
      wr(A_CUR, 32'h5A);
      wr(A_CTRL, 32'h3);
      cnt = 0;
      while (!irq && cnt < 600) begin @(negedge clk); cnt++; end
      check("R7 irq seen", {31'd0, irq}, 1);
      cnt = 0;
      irq_seen = 1'b0;
      while (cnt < 600) begin
        @(negedge clk); cnt++;
        if (cnt == 1) check("R7 one-cycle pulse", {31'd0, irq}, 0);
        if (irq) begin irq_seen = 1'b1; break; end
      end
      check("R3 period", cnt, {23'd0, VEC[i][8:0]});
    end

    // R2 / R3: counting start and hold
    wr(A_CTRL, 32'h0);
    wr(A_REL, 32'd20);
    wr(A_CUR, 32'h0);
    wr(A_CTRL, 32'h1);
    peek_t(A_CUR, v); check("R3 zero before reload", v, 0);
    @(negedge clk); peek_t(A_CUR, v); check("R3 reload loaded", v, 20);
    @(negedge clk); peek_t(A_CUR, v); check("R2 decrement", v, 19);
    @(negedge clk); peek_t(A_CUR, v); check("R2 decrement again", v, 18);
    peek_t(A_CTRL, v); check("R10 ctrl readback", v & 32'h3, 32'h1);
    wr(A_CTRL, 32'h0);
    peek_t(A_CUR, v); check("R2 last value", v, 17);
    repeat (4) @(negedge clk);
    peek_t(A_CUR, v); check("R2 hold when disabled", v, 17);

    // R4 / R7 masked: flag without irq
    wr(A_REL, 32'd3);
    wr(A_CUR, 32'h0);
    wr(A_CTRL, 32'h1);
    irq_seen = 1'b0;
    cnt = 0;
    v = peek(A_CTRL);
    #1 v = reg_rdata;
    while (v[FLAGB] == 1'b0 && cnt < 50) begin
      @(negedge clk); cnt++;
      if (irq) irq_seen = 1'b1;
      peek_t(A_CTRL, v);
    end
    check("R4 flag set", {31'd0, v[FLAGB]}, 1);
    peek_t(A_CUR, v); check("R4 counter at zero", v, 0);
    check("R7 irq masked", {31'd0, irq_seen}, 0);
    wr(A_CTRL, 32'h0);
    peek_t(A_CTRL, v); check("R10 ctrl write keeps flag", v[FLAGB], 1);
    rd_strobe(A_CTRL, v); check("R5 read returns flag", v[FLAGB], 1);
    peek_t(A_CTRL, v); check("R5 flag cleared by read", v[FLAGB], 0);

    // R6: write current clears value and flag
    wr(A_CTRL, 32'h1);
    cnt = 0;
    peek_t(A_CTRL, v);
    while (v[FLAGB] == 1'b0 && cnt < 50) begin
      @(negedge clk); cnt++; peek_t(A_CTRL, v);
    end
    @(negedge clk);
    wr(A_CTRL, 32'h0);
    peek_t(A_CUR, v); check("R6 counter non-zero before", {31'd0, (v != 0)}, 1);
    wr(A_CUR, 32'hAB);
    peek_t(A_CUR, v); check("R6 cur cleared", v, 0);
    peek_t(A_CTRL, v); check("R6 flag cleared", v[FLAGB], 0);

    // R8: reload 0 stops wrapping
    wr(A_REL, 32'd4);
    wr(A_CTRL, 32'h3);
    @(negedge clk); @(negedge clk);
    wr(A_REL, 32'd0);
    cnt = 0;
    peek_t(A_CTRL, v);
    while (v[FLAGB] == 1'b0 && cnt < 50) begin
      @(negedge clk); cnt++; peek_t(A_CTRL, v);
    end
    rd_strobe(A_CTRL, v);
    irq_seen = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (irq) irq_seen = 1'b1;
    end
    peek_t(A_CUR, v);  check("R8 stays zero", v, 0);
    peek_t(A_CTRL, v); check("R8 no new flag", v[FLAGB], 0);
    check("R8 no irq", {31'd0, irq_seen}, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule